// File: doc/BRIEF.md
# Parallel TFT Command Driver

This block sits between a user datapath and a small TFT display controller wired through an 8080-style parallel write bus. The user presents an 8-bit command code, a count of 16-bit words that belong to that command, and the current word. The block places the command on the bus with register select low. It then writes each data word with register select high. After every data word lands on the bus it pulses a one-cycle "sent" strobe, so the user can present the next word.

A busy flag covers the whole transaction, and chip select is low for the same span. The word count is set at run time and can be as large as one full frame of pixels, so a single memory-write command can refresh the whole screen. A command code of zero means idle. After a transaction ends, the block waits for the code to return to zero before it accepts a new one. Coming out of reset, the block holds the display's reset line low for a set number of cycles and accepts no command until that interval has passed.

Top module: `tft_cmd_driver`

## Requirements
- R1: After `rst` falls, `lcd_rst_n_o` stays low for exactly RST_HOLD (default 16) clock cycles and then goes high. `lcd_on_o` rises together with it. While `lcd_rst_n_o` is low, `busy_o` stays 0 and no bus write takes place.
- R2: `lcd_rd_n_o` is 1 at all times. When no transaction is running, `lcd_cs_n_o` and `lcd_wr_n_o` are 1 and `busy_o` is 0. A `cmd_i` of 0x00 starts nothing.
- R3: A nonzero `cmd_i` seen while idle and out of reset starts a transaction. Its first bus write has `lcd_rs_o`=0 and `lcd_db_o` = {8'h00, cmd_i}.
- R4: The command word is followed by exactly `len_i` data writes (`len_i` from 0 to 2^LEN_W-1, enough for 240x320 pixels), each with `lcd_rs_o`=1, carrying the words presented on `data_i` in order.
- R5: For each bus write, `lcd_wr_n_o` is low for exactly WR_LOW (2) cycles and then high for at least WR_HIGH (2) cycles before the next write. `lcd_db_o` does not change while `lcd_wr_n_o` is low. The display captures the word on the rising edge of `lcd_wr_n_o`.
- R6: `sent_o` is a one-cycle pulse raised once per data word, in the cycle after that word is put on the bus. The next word is taken from `data_i` one full write slot (WR_LOW+WR_HIGH cycles) later.
- R7: `last_o` is high only together with the `sent_o` pulse of the final data word.
- R8: `busy_o` rises in the cycle after the command is accepted and falls when the high phase of the final write ends. `lcd_cs_n_o` is low exactly while `busy_o` is high, and every write strobe falls inside that window.
- R9: With `len_i`=0, only the command word is written, no `sent_o` pulse occurs, and `busy_o` then clears.
- R10: After a transaction ends, the block starts no new one while `cmd_i` stays nonzero. It accepts a command again only after `cmd_i` has been 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 8 | Command code, 0 = idle |
| len_i | input | LEN_W | Number of data words after the command |
| data_i | input | 16 | Current data word |
| sent_o | output | 1 | One-cycle pulse per data word placed on the bus |
| last_o | output | 1 | Marks the final word's sent pulse |
| busy_o | output | 1 | Transaction in progress |
| lcd_on_o | output | 1 | Display power-on enable |
| lcd_rst_n_o | output | 1 | Display reset, active low |
| lcd_cs_n_o | output | 1 | Chip select, active low |
| lcd_rs_o | output | 1 | Register select: 0 command, 1 data |
| lcd_wr_n_o | output | 1 | Write strobe, active low |
| lcd_rd_n_o | output | 1 | Read strobe, held high |
| lcd_db_o | output | 16 | Parallel data bus |

## Verification
The two events that meet in one cycle are the completion of the last write, when busy falls, and a command code that is still nonzero at that moment. The bench provokes this by leaving the command asserted for many cycles after busy has dropped. It judges the result at the pins: no further write-strobe edge, chip select staying high, and busy staying low. A second overlap is the final word's sent pulse together with the last marker. The bench checks this by recording the pulse index at which the marker appears and comparing it with the programmed word count.

// File: rtl/tft_pkg.sv
package tft_pkg;

    localparam int CMD_W  = 8;
    localparam int DATA_W = 16;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_DATA = 2'd2,
        ST_DONE = 2'd3
    } seq_state_t;

    typedef struct packed {
        logic              cs_n;
        logic              rs;
        logic              wr_n;
        logic [DATA_W-1:0] db;
    } pbus_t;

    localparam pbus_t PBUS_IDLE = '{cs_n: 1'b1, rs: 1'b1, wr_n: 1'b1, db: '0};

    function automatic int slot_cycles(input int lo, input int hi);
        return lo + hi;
    endfunction

endpackage

// File: rtl/tft_rst_gen.sv
module tft_rst_gen #(
    parameter int HOLD = 16
) (
    input  logic clk,
    input  logic rst,
    output logic ready_o,
    output logic rst_n_o
);
    localparam int CNT_W = $clog2(HOLD + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            ready_o <= 1'b0;
            rst_n_o <= 1'b0;
        end else if (!ready_o) begin
            if (cnt_q == CNT_W'(HOLD - 1)) begin
                ready_o <= 1'b1;
                rst_n_o <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R1
    hold_count_chk: assert property (@(posedge clk) disable iff (rst)
        (!ready_o && cnt_q != CNT_W'(HOLD - 1)) |=> !rst_n_o);

endmodule

// File: rtl/tft_word_seq.sv
module tft_word_seq
    import tft_pkg::*;
#(
    parameter int LEN_W   = 17,
    parameter int WR_LOW  = 2,
    parameter int WR_HIGH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ready_i,
    input  logic [CMD_W-1:0]  cmd_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              sent_o,
    output logic              last_o,
    output logic              busy_o,
    output pbus_t             bus_o
);
    localparam int SLOT = slot_cycles(WR_LOW, WR_HIGH);
    localparam int PH_W = $clog2(SLOT) + 1;

    seq_state_t       st_q;
    logic [PH_W-1:0]  ph_q;
    logic [LEN_W-1:0] rem_q;
    logic             slot_end;

    assign slot_end = (ph_q == PH_W'(SLOT - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            ph_q   <= '0;
            rem_q  <= '0;
            bus_o  <= PBUS_IDLE;
            sent_o <= 1'b0;
            last_o <= 1'b0;
            busy_o <= 1'b0;
        end else begin
            sent_o <= 1'b0;
            last_o <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (ready_i && cmd_i != '0) begin
                        st_q       <= ST_CMD;
                        busy_o     <= 1'b1;
                        bus_o.cs_n <= 1'b0;
                        bus_o.rs   <= 1'b0;
                        bus_o.wr_n <= 1'b0;
                        bus_o.db   <= DATA_W'(cmd_i);
                        ph_q       <= '0;
                        rem_q      <= len_i;
                    end
                end
                ST_CMD, ST_DATA: begin
                    if (slot_end) begin
                        if (rem_q == '0) begin
                            st_q       <= ST_DONE;
                            busy_o     <= 1'b0;
                            bus_o.cs_n <= 1'b1;
                        end else begin
                            st_q       <= ST_DATA;
                            bus_o.rs   <= 1'b1;
                            bus_o.wr_n <= 1'b0;
                            bus_o.db   <= data_i;
                            ph_q       <= '0;
                            rem_q      <= rem_q - 1'b1;
                            sent_o     <= 1'b1;
                            last_o     <= (rem_q == LEN_W'(1));
                        end
                    end else begin
                        ph_q <= ph_q + 1'b1;
                        if ((ph_q + 1'b1) == PH_W'(WR_LOW))
                            bus_o.wr_n <= 1'b1;
                    end
                end
                ST_DONE: begin
                    if (cmd_i == '0)
                        st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // R6
    sent_single_chk: assert property (@(posedge clk) disable iff (rst)
        sent_o |=> !sent_o);

    // R7
    last_with_sent_chk: assert property (@(posedge clk) disable iff (rst)
        last_o |-> sent_o);

    // R8
    strobe_in_window_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_o.wr_n |-> (!bus_o.cs_n && busy_o));

    // R5
    db_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!bus_o.wr_n && $past(!bus_o.wr_n)) |-> $stable(bus_o.db));

    // R10
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_DONE && cmd_i != '0) |=> !busy_o);

endmodule

// File: rtl/tft_cmd_driver.sv
module tft_cmd_driver
    import tft_pkg::*;
#(
    parameter int LEN_W    = 17,
    parameter int RST_HOLD = 16,
    parameter int WR_LOW   = 2,
    parameter int WR_HIGH  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CMD_W-1:0]  cmd_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              sent_o,
    output logic              last_o,
    output logic              busy_o,
    output logic              lcd_on_o,
    output logic              lcd_rst_n_o,
    output logic              lcd_cs_n_o,
    output logic              lcd_rs_o,
    output logic              lcd_wr_n_o,
    output logic              lcd_rd_n_o,
    output logic [DATA_W-1:0] lcd_db_o
);
    logic  ready;
    pbus_t bus;

    tft_rst_gen #(.HOLD(RST_HOLD)) u_rst (
        .clk     (clk),
        .rst     (rst),
        .ready_o (ready),
        .rst_n_o (lcd_rst_n_o)
    );

    tft_word_seq #(
        .LEN_W   (LEN_W),
        .WR_LOW  (WR_LOW),
        .WR_HIGH (WR_HIGH)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .ready_i (ready),
        .cmd_i   (cmd_i),
        .len_i   (len_i),
        .data_i  (data_i),
        .sent_o  (sent_o),
        .last_o  (last_o),
        .busy_o  (busy_o),
        .bus_o   (bus)
    );

    assign lcd_on_o   = ready;
    assign lcd_cs_n_o = bus.cs_n;
    assign lcd_rs_o   = bus.rs;
    assign lcd_wr_n_o = bus.wr_n;
    assign lcd_db_o   = bus.db;
    assign lcd_rd_n_o = 1'b1;

    // R1
    hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !lcd_rst_n_o |-> (!busy_o && lcd_cs_n_o && lcd_wr_n_o));

endmodule

// File: tb/sim_tft_cmd_driver.sv
`timescale 1ns/1ps
module sim_tft_cmd_driver;
    localparam int LEN_W = 17;
    localparam int HOLD  = 16;
    localparam int WLO   = 2;
    localparam int WHI   = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  cmd_i = '0;
    logic [LEN_W-1:0] len_i = '0;
    logic [15:0] data_i = '0;
    logic sent_o, last_o, busy_o, lcd_on_o, lcd_rst_n_o, lcd_cs_n_o;
    logic lcd_rs_o, lcd_wr_n_o, lcd_rd_n_o;
    logic [15:0] lcd_db_o;

    tft_cmd_driver #(.LEN_W(LEN_W), .RST_HOLD(HOLD), .WR_LOW(WLO), .WR_HIGH(WHI)) u0 (
        .clk(clk), .rst(rst), .cmd_i(cmd_i), .len_i(len_i), .data_i(data_i),
        .sent_o(sent_o), .last_o(last_o), .busy_o(busy_o), .lcd_on_o(lcd_on_o),
        .lcd_rst_n_o(lcd_rst_n_o), .lcd_cs_n_o(lcd_cs_n_o), .lcd_rs_o(lcd_rs_o),
        .lcd_wr_n_o(lcd_wr_n_o), .lcd_rd_n_o(lcd_rd_n_o), .lcd_db_o(lcd_db_o));

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [16:0] cap [64];
    logic [15:0] wbuf [64];
    int cap_n, sent_n, last_at, last_cnt, bad_low, bad_high, bad_busy, bad_rd;
    int low_cnt, high_cnt;
    logic prev_wr = 1'b1;
    bit seen_write = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_mon();
        cap_n = 0; sent_n = 0; last_at = -1; last_cnt = 0;
        bad_low = 0; bad_high = 0; bad_busy = 0;
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (!lcd_rd_n_o) bad_rd++;
            if (sent_o) begin
                sent_n++;
                if (last_o) begin last_at = sent_n; last_cnt++; end
            end else if (last_o) last_cnt++;
            if (prev_wr && !lcd_wr_n_o) begin
                if (seen_write && high_cnt < WHI) bad_high++;
                low_cnt = 1;
            end else if (!lcd_wr_n_o) low_cnt++;
            if (!prev_wr && lcd_wr_n_o) begin
                if (cap_n < 64) cap[cap_n] = {lcd_rs_o, lcd_db_o};
                cap_n++;
                if (low_cnt != WLO) bad_low++;
                if (!busy_o || lcd_cs_n_o) bad_busy++;
                seen_write = 1;
                high_cnt = 1;
            end else if (lcd_wr_n_o) high_cnt++;
            prev_wr = lcd_wr_n_o;
        end
    end

    task automatic run_txn(input logic [7:0] c, input int n, input bit keep);
        clear_mon();
        @(negedge clk);
        cmd_i = c; len_i = LEN_W'(n); data_i = wbuf[0];
        do @(negedge clk); while (!busy_o);
        for (int k = 0; k < n; k++) begin
            do @(negedge clk); while (!sent_o);
            if (k + 1 < n) data_i = wbuf[k+1];
        end
        do @(negedge clk); while (busy_o);
        if (!keep) cmd_i = '0;
        repeat (3) @(negedge clk);
    endtask

    task automatic judge(input string tag, input logic [7:0] c, input int n);
        check(cap_n == n + 1, {tag, " R4 write count"}, cap_n, n + 1);
        check(cap[0] == {1'b0, 8'h00, c}, {tag, " R3 command word"}, int'(cap[0]), int'({1'b0, 8'h00, c}));
        for (int k = 0; k < n && k < 63; k++)
            check(cap[k+1] == {1'b1, wbuf[k]}, {tag, " R4 data word"}, int'(cap[k+1]), int'({1'b1, wbuf[k]}));
        check(bad_low == 0 && bad_high == 0, {tag, " R5 strobe widths"}, bad_low + bad_high, 0);
        check(sent_n == n, {tag, " R6 sent pulses"}, sent_n, n);
        check(last_cnt == (n > 0 ? 1 : 0) && last_at == (n > 0 ? n : -1), {tag, " R7 last position"}, last_at, n > 0 ? n : -1);
        check(bad_busy == 0 && !busy_o && lcd_cs_n_o, {tag, " R8 busy/cs window"}, bad_busy, 0);
    endtask

    task automatic t_reset();
        int n = 0, busy_hold = 0;
        bit on_early = 0;
        rst = 1'b1; cmd_i = 8'h11; len_i = '0;
        repeat (3) @(negedge clk);
        check(!busy_o && lcd_cs_n_o && lcd_wr_n_o && lcd_rd_n_o && !lcd_rst_n_o,
              "R2 reset outputs", {busy_o, lcd_cs_n_o, lcd_wr_n_o, lcd_rd_n_o, lcd_rst_n_o}, 5'b01110);
        clear_mon();
        rst = 1'b0;
        while (!lcd_rst_n_o) begin
            if (busy_o) busy_hold++;
            if (lcd_on_o) on_early = 1;
            @(negedge clk);
            n++;
        end
        check(n == HOLD, "R1 reset hold cycles", n, HOLD);
        check(busy_hold == 0 && cap_n == 0 && !on_early, "R1 quiet during hold", busy_hold + cap_n, 0);
        check(lcd_on_o, "R1 display on after hold", lcd_on_o, 1);
        do @(negedge clk); while (!busy_o);
        do @(negedge clk); while (busy_o);
        cmd_i = '0;
        repeat (3) @(negedge clk);
        check(cap_n == 1 && cap[0] == 17'h00011, "R1 command taken after hold", int'(cap[0]), 17);
    endtask

    task automatic t_zero_cmd();
        clear_mon();
        cmd_i = '0; len_i = LEN_W'(5);
        repeat (30) @(negedge clk);
        check(cap_n == 0 && !busy_o && lcd_cs_n_o, "R2 zero command idle", cap_n, 0);
    endtask

    task automatic t_column();
        wbuf[0] = 16'd0; wbuf[1] = 16'd0; wbuf[2] = 16'd0; wbuf[3] = 16'd239;
        run_txn(8'h2A, 4, 0);
        judge("column", 8'h2A, 4);
    endtask

    task automatic t_page();
        wbuf[0] = 16'd0; wbuf[1] = 16'd0; wbuf[2] = 16'd1; wbuf[3] = 16'h003F;
        run_txn(8'h2B, 4, 0);
        judge("page", 8'h2B, 4);
    endtask

    task automatic t_empty();
        run_txn(8'h29, 0, 0);
        judge("R9 empty", 8'h29, 0);
    endtask

    task automatic t_pixels();
        for (int k = 0; k < 40; k++) wbuf[k] = 16'(16'hA5C3 ^ (k * 16'h0F1D));
        run_txn(8'h2C, 40, 0);
        judge("pixels", 8'h2C, 40);
    endtask

    task automatic t_single_no_restart();
        wbuf[0] = 16'hBEEF;
        run_txn(8'h2C, 1, 1);
        judge("single", 8'h2C, 1);
        clear_mon();
        repeat (40) @(negedge clk);
        check(cap_n == 0 && !busy_o && lcd_cs_n_o, "R10 no restart while held", cap_n, 0);
        cmd_i = '0;
        repeat (2) @(negedge clk);
        wbuf[0] = 16'h1234;
        run_txn(8'h2C, 1, 0);
        check(cap_n == 2 && cap[1] == {1'b1, 16'h1234}, "R10 restart after zero", int'(cap[1]), int'({1'b1, 16'h1234}));
    endtask

    initial begin
        bad_rd = 0;
        low_cnt = 0; high_cnt = 0;
        clear_mon();
        t_reset();
        t_zero_cmd();
        t_column();
        t_page();
        t_empty();
        t_pixels();
        t_single_no_restart();
        check(bad_rd == 0, "R2 read strobe high", bad_rd, 0);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule